// File: doc/BRIEF.md
# Color Palette Access Port

This block sits between a narrow register bus and a 256-entry color lookup table. Each entry holds three 6-bit components: red, green and blue. Software selects entries through two index registers, one for loading and one for fetching. A single data register then moves the three components of an entry one at a time, always in the order red, green, blue.

A load is staged until the blue component arrives. The whole entry is then written in one cycle and the load index steps to the next entry. Fetches stream the components of the entry at the fetch index in the same order, and the fetch index steps after blue. A separate lookup port gives a pixel pipeline the full 18-bit entry for any index, one cycle after the index is presented, with no interference from bus traffic.

The bus has a write strobe, a read strobe and a 2-bit register select:
- 0 is the load index.
- 1 is the fetch index.
- 2 is the data register.
- 3 is unused.

Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `pal_port`

## Requirements
- R1: After reset every table entry is zero, both indices are 0, both component sequences point at red, `bus_rdata` is 0 and `pix_rgb` is 0.
- R2: A write with select 0 sets the load index and a write with select 1 sets the fetch index. A read of select 0 or 1 returns the current index, zero-extended. Select 3 is inert: writes to it change nothing and reads of it return 0.
- R3: Three writes to select 2 deliver red, green and blue in that order. After the third, the addressed entry holds all three, packed as {red, green, blue} with red in the top 6 bits of `pix_rgb`.
- R4: The addressed entry is not modified by the red or green writes. Only the blue write commits, and the load index is unchanged until then.
- R5: Only bits 5:0 of a data write are kept; bits 7:6 are ignored.
- R6: Three reads of select 2 return red, green and blue of the entry at the fetch index, each zero-extended to 8 bits (bits 7:6 read 0), one cycle after the read strobe.
- R7: After the blue write the load index increments, wrapping from 255 to 0.
- R8: After the blue read the fetch index increments, wrapping from 255 to 0.
- R9: Writing either index register restarts both the load and the fetch component sequences at red.
- R10: `pix_rgb` shows the entry addressed by `pix_idx` one cycle later, independent of bus activity. A commit made at the same clock edge becomes visible on the following lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select (0 load index, 1 fetch index, 2 data, 3 unused) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pix_idx | input | 8 | Lookup index from the pixel pipeline |
| pix_rgb | output | 18 | Looked-up entry {red, green, blue} |

## Verification
The bench goes after three kinds of fault.

The first is partial loads. A load that is abandoned after green by a new index write must leave its entry untouched. A design that commits early, or that forgets to restart the sequence, would scramble components across entries.

The second is index wrap at entry 255. A design with a bad wrap would step into a nonexistent entry or stall.

The third is mid-stream restarts of a fetch. Zero-extension of read data and the discarding of upper data bits are checked explicitly, because a faulty design would leak bits 7:6.

A long stretch of mixed random traffic, with lookups on every cycle, catches mix-ups between the two ports and the wrong lookup latency.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        SEL_LOAD_IDX  = 2'd0,
        SEL_FETCH_IDX = 2'd1,
        SEL_DATA      = 2'd2,
        SEL_UNUSED    = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2,
        PH_BAD = 2'd3
    } phase_e;

endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8,
    parameter int WORD_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [WORD_W-1:0] ra_word,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [WORD_W-1:0] rb_word_q
);

    logic [WORD_W-1:0] mem_q [ENTRIES];
    logic [WORD_W-1:0] rb_word_d;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic hit;
        assign hit = we && (wr_idx == IDX_W'(e));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[e] <= '0;
            end else if (hit) begin
                mem_q[e] <= wr_word;
            end
        end
    end

    always_comb begin
        ra_word = '0;
        if (int'(ra_idx) < ENTRIES) begin
            ra_word = mem_q[ra_idx];
        end
        rb_word_d = '0;
        if (int'(rb_idx) < ENTRIES) begin
            rb_word_d = mem_q[rb_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_word_q <= '0;
        end else begin
            rb_word_q <= rb_word_d;
        end
    end

endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8,
    parameter int COMP_W  = 6,
    parameter int BUS_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_sel,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [3*COMP_W-1:0] fetch_word,
    output logic [IDX_W-1:0]    load_idx,
    output logic [IDX_W-1:0]    fetch_idx,
    output logic [1:0]          load_phase,
    output logic [1:0]          fetch_phase,
    output logic                commit_en,
    output logic [3*COMP_W-1:0] commit_word
);

    localparam int WORD_W = 3 * COMP_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [IDX_W-1:0]  load_idx;
        logic [IDX_W-1:0]  fetch_idx;
        phase_e            load_ph;
        phase_e            fetch_ph;
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [BUS_W-1:0]  rdata;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [COMP_W-1:0] in_comp;
    logic [COMP_W-1:0] out_comp;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] idx);
        return (idx == LAST_IDX) ? '0 : idx + 1'b1;
    endfunction

    always_comb begin
        st_d        = st_q;
        commit_en   = 1'b0;
        in_comp     = bus_wdata[COMP_W-1:0];
        commit_word = {st_q.red, st_q.grn, in_comp};

        case (st_q.fetch_ph)
            PH_RED:  out_comp = fetch_word[WORD_W-1 -: COMP_W];
            PH_GRN:  out_comp = fetch_word[2*COMP_W-1 -: COMP_W];
            default: out_comp = fetch_word[COMP_W-1:0];
        endcase

        if (bus_rd) begin
            case (sel_e'(bus_sel))
                SEL_LOAD_IDX:  st_d.rdata = BUS_W'(st_q.load_idx);
                SEL_FETCH_IDX: st_d.rdata = BUS_W'(st_q.fetch_idx);
                SEL_DATA: begin
                    st_d.rdata = BUS_W'(out_comp);
                    case (st_q.fetch_ph)
                        PH_RED: st_d.fetch_ph = PH_GRN;
                        PH_GRN: st_d.fetch_ph = PH_BLU;
                        default: begin
                            st_d.fetch_ph  = PH_RED;
                            st_d.fetch_idx = step(st_q.fetch_idx);
                        end
                    endcase
                end
                default: st_d.rdata = '0;
            endcase
        end

        if (bus_wr) begin
            case (sel_e'(bus_sel))
                SEL_LOAD_IDX: begin
                    st_d.load_idx = bus_wdata[IDX_W-1:0];
                    st_d.load_ph  = PH_RED;
                    st_d.fetch_ph = PH_RED;
                end
                SEL_FETCH_IDX: begin
                    st_d.fetch_idx = bus_wdata[IDX_W-1:0];
                    st_d.load_ph   = PH_RED;
                    st_d.fetch_ph  = PH_RED;
                end
                SEL_DATA: begin
                    case (st_q.load_ph)
                        PH_RED: begin
                            st_d.red     = in_comp;
                            st_d.load_ph = PH_GRN;
                        end
                        PH_GRN: begin
                            st_d.grn     = in_comp;
                            st_d.load_ph = PH_BLU;
                        end
                        default: begin
                            commit_en     = 1'b1;
                            st_d.load_ph  = PH_RED;
                            st_d.load_idx = step(st_q.load_idx);
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{load_idx: '0, fetch_idx: '0, load_ph: PH_RED,
                      fetch_ph: PH_RED, red: '0, grn: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = st_q.rdata;
    assign load_idx    = st_q.load_idx;
    assign fetch_idx   = st_q.fetch_idx;
    assign load_phase  = st_q.load_ph;
    assign fetch_phase = st_q.fetch_ph;

endmodule

// File: rtl/pal_port.sv
module pal_port #(
    parameter int ENTRIES = 256,
    parameter int COMP_W  = 6,
    parameter int BUS_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int WORD_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_sel,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [WORD_W-1:0] pix_rgb
);

    logic [IDX_W-1:0]  load_idx;
    logic [IDX_W-1:0]  fetch_idx;
    logic [1:0]        load_phase;
    logic [1:0]        fetch_phase;
    logic              commit_en;
    logic [WORD_W-1:0] commit_word;
    logic [WORD_W-1:0] fetch_word;

    pal_ctrl #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .COMP_W  (COMP_W),
        .BUS_W   (BUS_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_sel     (bus_sel),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .fetch_word  (fetch_word),
        .load_idx    (load_idx),
        .fetch_idx   (fetch_idx),
        .load_phase  (load_phase),
        .fetch_phase (fetch_phase),
        .commit_en   (commit_en),
        .commit_word (commit_word)
    );

    pal_ram #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .WORD_W  (WORD_W)
    ) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (commit_en),
        .wr_idx    (load_idx),
        .wr_word   (commit_word),
        .ra_idx    (fetch_idx),
        .ra_word   (fetch_word),
        .rb_idx    (pix_idx),
        .rb_word_q (pix_rgb)
    );

endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk #(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8,
    parameter int BUS_W   = 8,
    parameter int COMP_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_sel,
    input logic [BUS_W-1:0] bus_rdata,
    input logic [IDX_W-1:0] load_idx,
    input logic [IDX_W-1:0] fetch_idx,
    input logic [1:0]       load_phase,
    input logic [1:0]       fetch_phase
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    assert_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == 2'd2) |=> (bus_rdata[BUS_W-1:COMP_W] == '0));

    assert_seq_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_sel == 2'd0 || bus_sel == 2'd1))
        |=> (load_phase == 2'd0 && fetch_phase == 2'd0));

    assert_load_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2 && load_phase == 2'd2)
        |=> (load_idx == (($past(load_idx) == LAST_IDX) ? '0 : $past(load_idx) + 1'b1)));

    assert_load_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2 && load_phase != 2'd2) |=> $stable(load_idx));

    assert_fetch_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == 2'd2 && fetch_phase == 2'd2)
        |=> (fetch_idx == (($past(fetch_idx) == LAST_IDX) ? '0 : $past(fetch_idx) + 1'b1)));

    assert_unused_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd3) |=> ($stable(load_idx) && $stable(fetch_idx)
                               && $stable(load_phase) && $stable(fetch_phase)));

    assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_phase != 2'd3 && fetch_phase != 2'd3));

endmodule

bind pal_port pal_port_chk #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .BUS_W   (BUS_W),
    .COMP_W  (COMP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_sel     (bus_sel),
    .bus_rdata   (bus_rdata),
    .load_idx    (load_idx),
    .fetch_idx   (fetch_idx),
    .load_phase  (load_phase),
    .fetch_phase (fetch_phase)
);

// File: tb/pal_port_bench.sv
module pal_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pix_idx = 8'd0;
    logic [17:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pal_port u_pal_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pix_idx   (pix_idx),
        .pix_rgb   (pix_rgb)
    );

    // Behavioural reference model
    logic [5:0] m_r [256];
    logic [5:0] m_g [256];
    logic [5:0] m_b [256];
    int         m_widx, m_ridx, m_wph, m_rph;
    logic [5:0] m_red, m_grn;
    logic [7:0] e_rdata;
    logic [17:0] e_pix;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                m_r[i] = 0; m_g[i] = 0; m_b[i] = 0;
            end
            m_widx = 0; m_ridx = 0; m_wph = 0; m_rph = 0;
            m_red = 0; m_grn = 0; e_rdata = 0; e_pix = 0;
        end else begin
            e_pix = {m_r[pix_idx], m_g[pix_idx], m_b[pix_idx]};
            if (bus_rd) begin
                case (bus_sel)
                    2'd0: e_rdata = 8'(m_widx);
                    2'd1: e_rdata = 8'(m_ridx);
                    2'd2: begin
                        if (m_rph == 0) e_rdata = {2'b00, m_r[m_ridx]};
                        else if (m_rph == 1) e_rdata = {2'b00, m_g[m_ridx]};
                        else e_rdata = {2'b00, m_b[m_ridx]};
                        m_rph = m_rph + 1;
                        if (m_rph == 3) begin
                            m_rph = 0;
                            m_ridx = (m_ridx + 1) % 256;
                        end
                    end
                    default: e_rdata = 0;
                endcase
            end
            if (bus_wr) begin
                case (bus_sel)
                    2'd0: begin m_widx = bus_wdata; m_wph = 0; m_rph = 0; end
                    2'd1: begin m_ridx = bus_wdata; m_wph = 0; m_rph = 0; end
                    2'd2: begin
                        if (m_wph == 0) m_red = bus_wdata[5:0];
                        else if (m_wph == 1) m_grn = bus_wdata[5:0];
                        else begin
                            m_r[m_widx] = m_red;
                            m_g[m_widx] = m_grn;
                            m_b[m_widx] = bus_wdata[5:0];
                            m_widx = (m_widx + 1) % 256;
                        end
                        m_wph = (m_wph + 1) % 3;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 read data stream", 32'(bus_rdata), 32'(e_rdata));
            check("R10 pixel lookup", 32'(pix_rgb), 32'(e_pix));
        end
    end

    task automatic bwr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = s;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic pchk(input logic [7:0] idx, input logic [17:0] exp, input string tag);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        check(tag, 32'(pix_rgb), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", 32'(bus_rdata), 32'h0);
        check("R1 pix after reset", 32'(pix_rgb), 32'h0);
        brd(2'd0, 8'd0, "R1 load index reset");
        brd(2'd1, 8'd0, "R1 fetch index reset");
        pchk(8'd200, 18'h0, "R1 entry zero");

        // Index registers and unused select
        bwr(2'd0, 8'd5);
        brd(2'd0, 8'd5, "R2 load index readback");
        bwr(2'd3, 8'hAA);
        brd(2'd3, 8'd0, "R2 unused select reads zero");
        brd(2'd0, 8'd5, "R2 unused write leaves index");

        // Staged load then commit
        bwr(2'd2, 8'h2A);
        bwr(2'd2, 8'h15);
        pchk(8'd5, 18'h0, "R4 no commit before blue");
        brd(2'd0, 8'd5, "R4 index held before blue");
        bwr(2'd2, 8'h3F);
        pchk(8'd5, {6'h2A, 6'h15, 6'h3F}, "R3 committed entry");
        brd(2'd0, 8'd6, "R7 load index steps");

        // Upper bits discarded
        bwr(2'd0, 8'd7);
        bwr(2'd2, 8'hFF);
        bwr(2'd2, 8'hC1);
        bwr(2'd2, 8'h80);
        pchk(8'd7, {6'h3F, 6'h01, 6'h00}, "R5 upper bits dropped");

        // Fetch stream
        bwr(2'd1, 8'd5);
        brd(2'd2, 8'h2A, "R6 red");
        brd(2'd2, 8'h15, "R6 green");
        brd(2'd2, 8'h3F, "R6 blue");
        brd(2'd1, 8'd6, "R8 fetch index steps");
        bwr(2'd1, 8'd7);
        brd(2'd2, 8'h3F, "R6 zero-extended red");

        // Wrap at the last entry
        bwr(2'd0, 8'd255);
        bwr(2'd2, 8'h01);
        bwr(2'd2, 8'h02);
        bwr(2'd2, 8'h03);
        brd(2'd0, 8'd0, "R7 load index wraps");
        pchk(8'd255, {6'h01, 6'h02, 6'h03}, "R3 last entry");
        bwr(2'd1, 8'd255);
        brd(2'd2, 8'h01, "R8 red at 255");
        brd(2'd2, 8'h02, "R8 green at 255");
        brd(2'd2, 8'h03, "R8 blue at 255");
        brd(2'd1, 8'd0, "R8 fetch index wraps");

        // Sequence restart on index writes
        bwr(2'd0, 8'd9);
        bwr(2'd2, 8'h11);
        bwr(2'd2, 8'h12);
        bwr(2'd0, 8'd10);
        bwr(2'd2, 8'h21);
        bwr(2'd2, 8'h22);
        bwr(2'd2, 8'h23);
        pchk(8'd9, 18'h0, "R9 abandoned load no effect");
        pchk(8'd10, {6'h21, 6'h22, 6'h23}, "R9 restarted load");
        bwr(2'd1, 8'd5);
        brd(2'd2, 8'h2A, "R9 first red");
        bwr(2'd1, 8'd5);
        brd(2'd2, 8'h2A, "R9 red again after fetch index write");
        bwr(2'd0, 8'd20);
        brd(2'd2, 8'h2A, "R9 red again after load index write");

        // Mixed random traffic with lookups every cycle
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            pix_idx   = 8'($urandom_range(0, 15));
            bus_sel   = 2'($urandom_range(0, 3));
            bus_wdata = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(250, 255))
                                                    : 8'($urandom_range(0, 255));
            if (bus_sel < 2) bus_wdata = bus_wdata % 16;
            bus_wr = ($urandom_range(0, 2) != 0);
            bus_rd = ($urandom_range(0, 1) != 0);
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule